// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit up-counter that serves one of two roles. As a system watchdog it asks for a chip restart when software fails to clear it within the selected window. As an interval timer it raises an interrupt flag each time the window elapses. Two per-cycle enable inputs stand for a fast and an auxiliary count clock, and the block follows one of them.

Software reaches the block through a small register bus with two word addresses. Address 0 is the control word. A write there only lands if its upper byte carries the unlock key 0x5A. Any other upper byte is treated as a runaway program and restarts the system. Reads of address 0 show a fixed signature byte in the upper half. Address 1 holds the interrupt flag and its local enable, and writes there need no key.

When a restart comes from this block, it resets its own control word, counter and local enable. It keeps the flag, so that software can later see that the watchdog caused the restart.

Top module: `keyed_watchdog`

## Requirements
- R1: A write to address 0 whose bits [15:8] equal 0x5A stores the control fields from the low byte: bit 7 hold, bit 4 interval mode (1) or watchdog mode (0), bit 2 count source (1 auxiliary, 0 fast), bits [1:0] window select.
- R2: A write to address 0 with any other upper byte leaves the written value unused. In the next cycle `sys_rst_req` is high, the control word reads 0x00 in its low byte, and the counter is zero.
- R3: Reading address 0 gives 0x69 in bits [15:8] and the stored control fields in the low byte. Bit 3 and the other unused bits read 0. Reading address 1 gives the flag in bit 0 and the local enable in bit 1.
- R4: Window select 00, 01, 10 and 11 makes the counter expire after 32768, 8192, 512 and 64 source ticks counted from a clear.
- R5: In watchdog mode an expiry raises `sys_rst_req` for one cycle in the following cycle, returns the control word to 0, and sets the flag.
- R6: In interval mode an expiry sets the flag in the following cycle and does not request a restart.
- R7: A keyed control write with bit 3 set zeroes the counter. The bit is not stored.
- R8: Only the enable input chosen by the source bit advances the counter.
- R9: While the hold bit is set the counter keeps its value. Counting resumes from that value when hold is cleared.
- R10: `irq_req` is high exactly when the flag, the local enable, `gie` and interval mode are all set.
- R11: In interval mode `irq_ack` clears the flag. In watchdog mode `irq_ack` has no effect. A write to address 1 sets the flag from bit 0 and the local enable from bit 1. An expiry in the same cycle as a clear leaves the flag set.
- R12: After reset the control word, counter, flag and enable are all 0: watchdog mode, fast source, 32768-tick window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_ce | input | 1 | Tick enable of the fast count clock |
| aux_ce | input | 1 | Tick enable of the auxiliary count clock |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 1 | Word address: 0 control, 1 flag/enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| sys_rst_req | output | 1 | One-cycle system restart request |
| irq_flag | output | 1 | Interrupt / restart-cause flag |
| irq_req | output | 1 | Interrupt request |

## Verification
A faulty counter or window decode shows up as a flag or restart that arrives one tick early or late. The bench therefore samples just before and just at the expected expiry tick for several windows. A control word left in a wrong state shows at once in the next read of address 0, and also in whether the next expiry gives a restart or only a flag. Faults in the key check or the interrupt gating show within one cycle of the offending write, or of the `gie` and `irq_ack` change, on `sys_rst_req` and `irq_req`.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    // Stored control fields. The clear bit is an action and is never stored.
    typedef struct packed {
        logic       hold;
        logic       ivl_mode;
        logic       src_aux;
        logic [1:0] win_sel;
    } ctl_t;

    localparam int CTL_HOLD_BIT  = 7;
    localparam int CTL_MODE_BIT  = 4;
    localparam int CTL_CLR_BIT   = 3;
    localparam int CTL_SRC_BIT   = 2;

    localparam int IRQ_FLAG_BIT  = 0;
    localparam int IRQ_EN_BIT    = 1;

    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        logic [7:0] b;
        b = 8'h00;
        b[CTL_HOLD_BIT] = c.hold;
        b[CTL_MODE_BIT] = c.ivl_mode;
        b[CTL_SRC_BIT]  = c.src_aux;
        b[1:0]          = c.win_sel;
        return b;
    endfunction

    function automatic ctl_t byte_to_ctl(input logic [7:0] b);
        ctl_t c;
        c.hold     = b[CTL_HOLD_BIT];
        c.ivl_mode = b[CTL_MODE_BIT];
        c.src_aux  = b[CTL_SRC_BIT];
        c.win_sel  = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/kwd_tick_sel.sv
module kwd_tick_sel #(
    parameter int CNT_W    = 16,
    parameter int LG_LONG  = 15,
    parameter int LG_MID   = 13,
    parameter int LG_SHORT = 9,
    parameter int LG_TINY  = 6
) (
    input  logic             fast_ce,
    input  logic             aux_ce,
    input  logic             src_aux,
    input  logic [1:0]       win_sel,
    output logic             tick,
    output logic [CNT_W-1:0] win_mask
);

    localparam int NUM_WIN = 4;

    logic [CNT_W-1:0] masks [NUM_WIN];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam int LG = (i == 0) ? LG_LONG  :
                            (i == 1) ? LG_MID   :
                            (i == 2) ? LG_SHORT : LG_TINY;
        assign masks[i] = {CNT_W{1'b1}} >> (CNT_W - LG);
    end

    always_comb begin
        tick     = src_aux ? aux_ce : fast_ce;
        win_mask = masks[win_sel];
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             clr,
    input  logic [CNT_W-1:0] win_mask,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       adv;

    always_comb begin
        st_d   = st_q;
        adv    = tick && !hold;
        expire = adv && ((st_q.cnt & win_mask) == win_mask);
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
    import kwd_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = 8'h5A,
    parameter logic [7:0] READ_SIG   = 8'h69
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        gie,
    input  logic        irq_ack,
    input  logic        expire,
    output ctl_t        ctl,
    output logic        cnt_clr,
    output logic        sys_rst_req,
    output logic        irq_flag,
    output logic        irq_req
);

    typedef struct packed {
        ctl_t ctl;
        logic flag;
        logic irq_en;
        logic rst_req;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic wr_ctl, wr_irq, key_ok, good_wr, bad_wr, wdt_fire, ivl_fire, restart;
    logic unused_wdata;

    always_comb begin
        st_d     = st_q;
        wr_ctl   = bus_en && bus_we && !bus_addr;
        wr_irq   = bus_en && bus_we &&  bus_addr;
        key_ok   = bus_wdata[15:8] == UNLOCK_KEY;
        good_wr  = wr_ctl && key_ok;
        bad_wr   = wr_ctl && !key_ok;
        wdt_fire = expire && !st_q.ctl.ivl_mode;
        ivl_fire = expire &&  st_q.ctl.ivl_mode;
        restart  = bad_wr || wdt_fire;

        // control word
        if (restart) begin
            st_d.ctl = '0;
        end else if (good_wr) begin
            st_d.ctl = byte_to_ctl(bus_wdata[7:0]);
        end

        // counter clear: keyed clear request or system restart
        cnt_clr = restart || (good_wr && bus_wdata[CTL_CLR_BIT]);

        // local enable
        if (restart) begin
            st_d.irq_en = 1'b0;
        end else if (wr_irq) begin
            st_d.irq_en = bus_wdata[IRQ_EN_BIT];
        end

        // flag: a setting event outranks every clearing event
        if (restart || ivl_fire) begin
            st_d.flag = 1'b1;
        end else if (wr_irq) begin
            st_d.flag = bus_wdata[IRQ_FLAG_BIT];
        end else if (irq_ack && st_q.ctl.ivl_mode) begin
            st_d.flag = 1'b0;
        end

        st_d.rst_req = restart;

        // read mux
        if (bus_addr) begin
            bus_rdata = 16'h0000;
            bus_rdata[IRQ_FLAG_BIT] = st_q.flag;
            bus_rdata[IRQ_EN_BIT]   = st_q.irq_en;
        end else begin
            bus_rdata = {READ_SIG, ctl_to_byte(st_q.ctl)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unused_wdata = ^{bus_wdata[6:5], bus_wdata[15:8]};

    assign ctl         = st_q.ctl;
    assign sys_rst_req = st_q.rst_req;
    assign irq_flag    = st_q.flag;
    assign irq_req     = st_q.flag && st_q.irq_en && gie && st_q.ctl.ivl_mode;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int         CNT_W      = 16,
    parameter logic [7:0] UNLOCK_KEY = 8'h5A,
    parameter logic [7:0] READ_SIG   = 8'h69
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_ce,
    input  logic        aux_ce,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        gie,
    input  logic        irq_ack,
    output logic        sys_rst_req,
    output logic        irq_flag,
    output logic        irq_req
);

    ctl_t             ctl;
    logic             cnt_clr;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] win_mask;
    logic [CNT_W-1:0] cnt;

    kwd_ctrl #(
        .UNLOCK_KEY (UNLOCK_KEY),
        .READ_SIG   (READ_SIG)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .gie         (gie),
        .irq_ack     (irq_ack),
        .expire      (expire),
        .ctl         (ctl),
        .cnt_clr     (cnt_clr),
        .sys_rst_req (sys_rst_req),
        .irq_flag    (irq_flag),
        .irq_req     (irq_req)
    );

    kwd_tick_sel #(
        .CNT_W (CNT_W)
    ) u_tick (
        .fast_ce  (fast_ce),
        .aux_ce   (aux_ce),
        .src_aux  (ctl.src_aux),
        .win_sel  (ctl.win_sel),
        .tick     (tick),
        .win_mask (win_mask)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold     (ctl.hold),
        .clr      (cnt_clr),
        .win_mask (win_mask),
        .cnt      (cnt),
        .expire   (expire)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rst_req,
    input logic             irq_req,
    input logic             irq_flag,
    input logic             gie,
    input logic             bus_addr,
    input logic [15:0]      bus_rdata,
    input logic             hold,
    input logic             ivl_mode,
    input logic             cnt_clr,
    input logic             expire,
    input logic [CNT_W-1:0] cnt
);

    p_restart_zero_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (cnt == '0 && !hold && !ivl_mode));

    p_signature_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> (bus_rdata[15:8] == 8'h69 && !bus_rdata[3]));

    p_wdt_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ivl_mode) |=> sys_rst_req);

    p_ivl_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ivl_mode) |=> (irq_flag && !sys_rst_req));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !cnt_clr) |=> (cnt == $past(cnt)));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_flag && gie && ivl_mode));

endmodule

bind keyed_watchdog kwd_checker #(.CNT_W(CNT_W)) u_kwd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_req (sys_rst_req),
    .irq_req     (irq_req),
    .irq_flag    (irq_flag),
    .gie         (gie),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .hold        (ctl.hold),
    .ivl_mode    (ctl.ivl_mode),
    .cnt_clr     (cnt_clr),
    .expire      (expire),
    .cnt         (cnt)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_ce = 1'b0, aux_ce = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        gie = 1'b0, irq_ack = 1'b0;
    logic        sys_rst_req, irq_flag, irq_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    keyed_watchdog dut (
        .clk(clk), .rst_n(rst_n), .fast_ce(fast_ce), .aux_ce(aux_ce),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
        .irq_ack(irq_ack), .sys_rst_req(sys_rst_req),
        .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // vector: [34] addr, [33:18] write data, [17:2] expected read, [1] expected restart, [0] spare
    localparam int NVEC = 7;
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 16'h5A13, 16'h6913, 1'b0, 1'b0},   // R1 R3 interval, window 64
        {1'b0, 16'h5A07, 16'h6907, 1'b0, 1'b0},   // R1 R3 aux source, window 64
        {1'b0, 16'h5A9A, 16'h6992, 1'b0, 1'b0},   // R3 R7 clear bit reads 0
        {1'b1, 16'h0003, 16'h0003, 1'b0, 1'b0},   // R11 flag and enable written
        {1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0},   // R11 both cleared
        {1'b0, 16'h3C13, 16'h6900, 1'b1, 1'b0},   // R2 wrong key restarts
        {1'b0, 16'h5A10, 16'h6910, 1'b0, 1'b0}    // R1 keyed write after restart
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run(input int n, input logic use_aux);
        fast_ce = !use_aux; aux_ce = use_aux;
        repeat (n) step();
        fast_ce = 1'b0; aux_ce = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(1'b0, r); chk("R12 reset control", r, 16'h6900);
        rd(1'b1, r); chk("R12 reset flag/enable", r, 16'h0000);
        chk("R12 reset restart", {15'b0, sys_rst_req}, 16'h0);

        // R4 R5 default 32768 window in watchdog mode
        run(32767, 1'b0);
        chk("R4 default window not yet", {15'b0, sys_rst_req}, 16'h0);
        run(1, 1'b0);
        chk("R5 default window restart", {15'b0, sys_rst_req}, 16'h1);
        step();
        chk("R5 restart lasts one cycle", {15'b0, sys_rst_req}, 16'h0);
        rd(1'b1, r); chk("R5 flag records restart", r, 16'h0001);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        rd(1'b1, r); chk("R11 ack ignored in watchdog mode", r, 16'h0001);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][34], VEC[i][33:18]);
            chk($sformatf("R2 restart vec%0d", i), {15'b0, sys_rst_req}, {15'b0, VEC[i][1]});
            rd(VEC[i][34], r);
            chk($sformatf("R3 readback vec%0d", i), r, VEC[i][17:2]);
        end
        step();

        // R5 watchdog with 512 window
        wr(1'b0, 16'h5A0A);
        run(511, 1'b0);
        chk("R5 512 window not yet", {15'b0, sys_rst_req}, 16'h0);
        run(1, 1'b0);
        chk("R5 512 window restart", {15'b0, sys_rst_req}, 16'h1);
        rd(1'b0, r); chk("R5 control back to default", r, 16'h6900);
        step();

        // R6 R10 R11 interval 64
        wr(1'b1, 16'h0002);
        wr(1'b0, 16'h5A1B);
        run(63, 1'b0);
        chk("R6 64 window not yet", {15'b0, irq_flag}, 16'h0);
        run(1, 1'b0);
        chk("R6 64 window flag", {15'b0, irq_flag}, 16'h1);
        chk("R6 no restart in interval", {15'b0, sys_rst_req}, 16'h0);
        chk("R10 gie low masks", {15'b0, irq_req}, 16'h0);
        gie = 1'b1; #1;
        chk("R10 request with gie", {15'b0, irq_req}, 16'h1);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        chk("R11 ack clears flag", {15'b0, irq_flag}, 16'h0);
        chk("R10 request drops", {15'b0, irq_req}, 16'h0);
        run(64, 1'b0);
        chk("R6 second interval flag", {15'b0, irq_flag}, 16'h1);
        wr(1'b1, 16'h0002);
        chk("R11 software clear", {15'b0, irq_flag}, 16'h0);
        gie = 1'b0;

        // R4 R7 512 and 8192 windows, interval mode
        wr(1'b0, 16'h5A1A);
        run(511, 1'b0);
        chk("R4 512 not yet", {15'b0, irq_flag}, 16'h0);
        run(1, 1'b0);
        chk("R4 512 flag", {15'b0, irq_flag}, 16'h1);
        wr(1'b0, 16'h5A19);
        wr(1'b1, 16'h0000);
        run(8191, 1'b0);
        chk("R4 8192 not yet", {15'b0, irq_flag}, 16'h0);
        run(1, 1'b0);
        chk("R4 8192 flag", {15'b0, irq_flag}, 16'h1);

        // R8 source select
        wr(1'b0, 16'h5A1F);
        wr(1'b1, 16'h0000);
        run(100, 1'b0);
        chk("R8 fast ignored on aux source", {15'b0, irq_flag}, 16'h0);
        run(64, 1'b1);
        chk("R8 aux ticks expire", {15'b0, irq_flag}, 16'h1);

        // R9 hold
        wr(1'b0, 16'h5A1B);
        wr(1'b1, 16'h0000);
        run(32, 1'b0);
        wr(1'b0, 16'h5A93);
        run(100, 1'b0);
        chk("R9 held counter no flag", {15'b0, irq_flag}, 16'h0);
        wr(1'b0, 16'h5A13);
        run(31, 1'b0);
        chk("R9 resumed not yet", {15'b0, irq_flag}, 16'h0);
        run(1, 1'b0);
        chk("R9 resumed from held value", {15'b0, irq_flag}, 16'h1);

        // R7 periodic clear keeps watchdog quiet
        wr(1'b0, 16'h5A0B);
        for (int k = 0; k < 3; k++) begin
            run(50, 1'b0);
            wr(1'b0, 16'h5A0B);
        end
        chk("R7 cleared watchdog quiet", {15'b0, sys_rst_req}, 16'h0);
        run(63, 1'b0);
        chk("R7 counted from clear", {15'b0, sys_rst_req}, 16'h0);
        run(1, 1'b0);
        chk("R7 expiry after clear", {15'b0, sys_rst_req}, 16'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule